// File: doc/BRIEF.md
# Supervisor Status Pair with Double-Trap Bit Gating

This block keeps two supervisor-level status words: the one seen by the host supervisor and the one seen by a guest supervisor. It also keeps the two enable bits that govern the supervisor double-trap flag, one at machine level and one at hypervisor level. Software writes each status word through its own plain write port, with a strobe and a full-width data word. The block merges the data under a write mask and keeps the result. Each read port always presents the stored word through a read mask. A static input says whether the double-trap feature exists at all.

The double-trap flag takes part in a status word only while the enable for that view is on. The host view uses the machine-level enable. The guest view uses the hypervisor-level enable, and that enable only counts while the machine-level one is also on. When the enable is off, the flag keeps its stored value on writes and reads as zero. Whenever a write leaves the stored flag at one, the interrupt-enable bit of that word is cleared in the same write. The positions of the interrupt-enable bit and the flag, and the set of other writable fields, are parameters.

The ports carry register writes, not streams. Every strobe is taken in the cycle it is high, so there is no valid/ready pair and no back-pressure. Every write gates the flag with the enable values held before the clock edge. Every read gates it with the enable values held now.

Top module: `sstat_dbltrp`

## Requirements
- R1: After reset, both stored status words and both enables are 0, so every output reads 0.
- R2: A status write sets each bit in BASE_WMASK (default bits 1, 5, 8, 18, 19) to the write data. Bits outside BASE_WMASK and the flag always read 0.
- R3: The machine enable (`menv_dte`) is written from `menv_dte_wd` only when `dbltrp_impl` is 1. Otherwise a write leaves it unchanged.
- R4: The stored hypervisor enable cannot become 1 while the machine enable is 0. `henv_dte` reads as 0 whenever the machine enable is 0, and shows the stored value again when the machine enable returns to 1.
- R5: A host status write changes the flag (bit SDT_BIT, default 24) only when the feature is present and the machine enable is 1. Otherwise the stored flag keeps its value.
- R6: A guest status write changes the flag only when the effective hypervisor enable (`henv_dte`) is 1.
- R7: If the flag is 1 after the merge of a write, the interrupt-enable bit (SIE_BIT, default 1) is stored as 0. This includes a write of 1 to both bits, and a write while the flag is locked at 1.
- R8: The flag reads as 0 in the host view while the machine enable is 0, and in the guest view while `henv_dte` is 0. The stored flag shows again when the enable returns.
- R9: If an enable write and a status write fall in the same cycle, the status write is gated by the enable value from before that edge. Reads from the next cycle on use the new enable.
- R10: With `dbltrp_impl` at 0, neither enable can be set and the flag is never writable in either view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbltrp_impl | input | 1 | Static flag: the double-trap feature is present |
| menv_dte_we | input | 1 | Write strobe for the machine-level enable |
| menv_dte_wd | input | 1 | New value for the machine-level enable |
| henv_dte_we | input | 1 | Write strobe for the hypervisor-level enable |
| henv_dte_wd | input | 1 | New value for the hypervisor-level enable |
| s_we | input | 1 | Host status write strobe |
| s_wd | input | STAT_W | Host status write data |
| vs_we | input | 1 | Guest status write strobe |
| vs_wd | input | STAT_W | Guest status write data |
| s_rdata | output | STAT_W | Masked host status read value |
| vs_rdata | output | STAT_W | Masked guest status read value |
| s_sie | output | 1 | Host interrupt-enable bit as read |
| s_sdt | output | 1 | Host double-trap flag as read |
| vs_sie | output | 1 | Guest interrupt-enable bit as read |
| vs_sdt | output | 1 | Guest double-trap flag as read |
| menv_dte | output | 1 | Machine-level enable as read |
| henv_dte | output | 1 | Effective hypervisor-level enable as read |

## Verification
Two functions can meet in one cycle: an enable write, and a status write that the old enable must gate. The bench drives both strobes in the same cycle, in both directions. In one case the enable is turned off while the flag is cleared. In the other the enable is turned on while the flag is set. The result is judged by first reading with the new enable, then switching the enable back to expose the stored flag. A behavioural model, stepped on every clock, compares all outputs during these cycles and during a random burst of mixed writes.

// File: rtl/sstat_dbltrp_pkg.sv
package sstat_dbltrp_pkg;
  typedef enum int {
    VIEW_HOST  = 0,
    VIEW_GUEST = 1
  } stat_view_e;

  localparam int NUM_VIEWS = 2;
endpackage

// File: rtl/sstat_envcfg_dte.sv
module sstat_envcfg_dte (
  input  logic clk,
  input  logic rst_n,
  input  logic impl,
  input  logic m_we,
  input  logic m_wd,
  input  logic h_we,
  input  logic h_wd,
  output logic m_eff,
  output logic h_eff
);
  logic m_q;
  logic h_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q <= 1'b0;
      h_q <= 1'b0;
    end else begin
      if (m_we && impl) m_q <= m_wd;
      if (h_we && impl) h_q <= h_wd & m_q & impl;
    end
  end

  assign m_eff = m_q & impl;
  assign h_eff = h_q & m_eff;

  AST_MDTE_NEEDS_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_we && !impl) |=> $stable(m_q)); // R3
  AST_HDTE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && !m_eff) |=> !h_q); // R4
endmodule

// File: rtl/sstat_view.sv
module sstat_view #(
  parameter int W = 64,
  parameter int SIE_BIT = 1,
  parameter int SDT_BIT = 24,
  parameter logic [W-1:0] BASE_WMASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         impl,
  input  logic         dte,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] rdata
);
  localparam logic [W-1:0] SDT_M = {{(W-1){1'b0}}, 1'b1} << SDT_BIT;

  logic [W-1:0] stat_q;
  logic [W-1:0] wmask;
  logic [W-1:0] merged;
  logic [W-1:0] nxt;
  logic         sdt_live;

  assign sdt_live = impl & dte;

  always_comb begin
    wmask  = BASE_WMASK | (sdt_live ? SDT_M : '0);
    merged = (stat_q & ~wmask) | (wd & wmask);
    nxt    = merged;
    if (merged[SDT_BIT]) nxt[SIE_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else if (we) stat_q <= nxt;
  end

  assign rdata = stat_q & (BASE_WMASK | (sdt_live ? SDT_M : '0));

  AST_SDT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sdt_live) |=> (stat_q[SDT_BIT] == $past(stat_q[SDT_BIT]))); // R5, R6
  AST_SDT_CLEARS_SIE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sdt_live && wd[SDT_BIT]) |=> !stat_q[SIE_BIT]); // R7
  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sdt_live |-> !rdata[SDT_BIT]); // R8
endmodule

// File: rtl/sstat_dbltrp.sv
module sstat_dbltrp
  import sstat_dbltrp_pkg::*;
#(
  parameter int STAT_W = 64,
  parameter int SIE_BIT = 1,
  parameter int SDT_BIT = 24,
  parameter logic [STAT_W-1:0] BASE_WMASK = 64'h0000_0000_000C_0122
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbltrp_impl,
  input  logic              menv_dte_we,
  input  logic              menv_dte_wd,
  input  logic              henv_dte_we,
  input  logic              henv_dte_wd,
  input  logic              s_we,
  input  logic [STAT_W-1:0] s_wd,
  input  logic              vs_we,
  input  logic [STAT_W-1:0] vs_wd,
  output logic [STAT_W-1:0] s_rdata,
  output logic [STAT_W-1:0] vs_rdata,
  output logic              s_sie,
  output logic              s_sdt,
  output logic              vs_sie,
  output logic              vs_sdt,
  output logic              menv_dte,
  output logic              henv_dte
);
  logic              m_eff;
  logic              h_eff;
  logic              v_dte [NUM_VIEWS];
  logic              v_we  [NUM_VIEWS];
  logic [STAT_W-1:0] v_wd  [NUM_VIEWS];
  logic [STAT_W-1:0] v_rd  [NUM_VIEWS];

  sstat_envcfg_dte u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .impl  (dbltrp_impl),
    .m_we  (menv_dte_we),
    .m_wd  (menv_dte_wd),
    .h_we  (henv_dte_we),
    .h_wd  (henv_dte_wd),
    .m_eff (m_eff),
    .h_eff (h_eff)
  );

  assign v_dte[VIEW_HOST]  = m_eff;
  assign v_dte[VIEW_GUEST] = h_eff;
  assign v_we[VIEW_HOST]   = s_we;
  assign v_we[VIEW_GUEST]  = vs_we;
  assign v_wd[VIEW_HOST]   = s_wd;
  assign v_wd[VIEW_GUEST]  = vs_wd;

  for (genvar gi = 0; gi < NUM_VIEWS; gi++) begin : g_view
    sstat_view #(
      .W          (STAT_W),
      .SIE_BIT    (SIE_BIT),
      .SDT_BIT    (SDT_BIT),
      .BASE_WMASK (BASE_WMASK)
    ) u_view (
      .clk   (clk),
      .rst_n (rst_n),
      .impl  (dbltrp_impl),
      .dte   (v_dte[gi]),
      .we    (v_we[gi]),
      .wd    (v_wd[gi]),
      .rdata (v_rd[gi])
    );
  end

  assign s_rdata  = v_rd[VIEW_HOST];
  assign vs_rdata = v_rd[VIEW_GUEST];
  assign s_sie    = s_rdata[SIE_BIT];
  assign s_sdt    = s_rdata[SDT_BIT];
  assign vs_sie   = vs_rdata[SIE_BIT];
  assign vs_sdt   = vs_rdata[SDT_BIT];
  assign menv_dte = m_eff;
  assign henv_dte = h_eff;

  AST_GUEST_NEEDS_HOST_EN: assert property (@(posedge clk) disable iff (!rst_n)
    henv_dte |-> menv_dte); // R4
  AST_NO_FEATURE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !dbltrp_impl |-> (!s_sdt && !vs_sdt && !menv_dte)); // R10
endmodule

// File: tb/test_sstat_dbltrp.sv
module test_sstat_dbltrp;
  localparam int W = 64;
  localparam int SIE = 1;
  localparam int SDT = 24;
  localparam logic [W-1:0] BASE = 64'h0000_0000_000C_0122;
  localparam logic [W-1:0] SDT_M = 64'h1 << SDT;
  localparam logic [W-1:0] SIE_M = 64'h1 << SIE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic impl = 1'b1;
  logic m_we = 1'b0, m_wd = 1'b0, h_we = 1'b0, h_wd = 1'b0;
  logic s_we = 1'b0, vs_we = 1'b0;
  logic [W-1:0] s_wd = '0, vs_wd = '0;
  logic [W-1:0] s_rdata, vs_rdata;
  logic s_sie, s_sdt, vs_sie, vs_sdt, menv_dte, henv_dte;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string phase = "R1";
  bit cmp_on = 1'b0;

  logic mdl_m, mdl_h;
  logic [W-1:0] mdl_s, mdl_vs;

  always #5 clk = ~clk;

  sstat_dbltrp i_sstat_dbltrp (
    .clk(clk), .rst_n(rst_n), .dbltrp_impl(impl),
    .menv_dte_we(m_we), .menv_dte_wd(m_wd), .henv_dte_we(h_we), .henv_dte_wd(h_wd),
    .s_we(s_we), .s_wd(s_wd), .vs_we(vs_we), .vs_wd(vs_wd),
    .s_rdata(s_rdata), .vs_rdata(vs_rdata), .s_sie(s_sie), .s_sdt(s_sdt),
    .vs_sie(vs_sie), .vs_sdt(vs_sdt), .menv_dte(menv_dte), .henv_dte(henv_dte)
  );

  function automatic logic [W-1:0] merge_w(logic [W-1:0] old, logic [W-1:0] d, logic live);
    logic [W-1:0] v;
    for (int b = 0; b < W; b++) begin
      if (BASE[b] || (live && b == SDT)) v[b] = d[b];
      else v[b] = old[b];
    end
    if (v[SDT] == 1'b1) v[SIE] = 1'b0;
    return v;
  endfunction

  function automatic logic [W-1:0] rd_view(logic [W-1:0] st, logic en);
    logic [W-1:0] r;
    r = st & BASE;
    if (en && st[SDT]) r[SDT] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    logic me, he;
    me = mdl_m & impl;
    he = mdl_h & me;
    if (!rst_n) begin
      mdl_m = 1'b0; mdl_h = 1'b0; mdl_s = '0; mdl_vs = '0;
    end else begin
      if (s_we) mdl_s = merge_w(mdl_s, s_wd, me);
      if (vs_we) mdl_vs = merge_w(mdl_vs, vs_wd, he);
      if (h_we && impl) mdl_h = h_wd & me;
      if (m_we && impl) mdl_m = m_wd;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      logic me, he;
      logic [W-1:0] es, ev;
      me = mdl_m & impl;
      he = mdl_h & me;
      es = rd_view(mdl_s, me);
      ev = rd_view(mdl_vs, he);
      total++;
      if (s_rdata !== es || vs_rdata !== ev || menv_dte !== me || henv_dte !== he ||
          s_sie !== es[SIE] || s_sdt !== es[SDT] || vs_sie !== ev[SIE] || vs_sdt !== ev[SDT]) begin
        bad++;
        $display("FAIL %s model: s=%h vs=%h m=%b h=%b expected s=%h vs=%h m=%b h=%b",
                 phase, s_rdata, vs_rdata, menv_dte, henv_dte, es, ev, me, he);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit mw, bit md, bit hw, bit hd, bit sw, logic [W-1:0] sd,
                     bit vw, logic [W-1:0] vd);
    @(negedge clk); #1;
    m_we = mw; m_wd = md; h_we = hw; h_wd = hd;
    s_we = sw; s_wd = sd; vs_we = vw; vs_wd = vd;
    @(negedge clk); #1;
    m_we = 0; h_we = 0; s_we = 0; vs_we = 0;
  endtask

  task automatic do_reset(bit imp);
    @(negedge clk); #1;
    cmp_on = 1'b0; rst_n = 1'b0; impl = imp;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
  endtask

  initial begin
    do_reset(1'b1);
    phase = "R1";
    chk("R1 s_rdata", s_rdata, '0);
    chk("R1 vs_rdata", vs_rdata, '0);
    chk("R1 enables", {menv_dte, henv_dte}, '0);

    phase = "R2";
    cyc(0, 0, 0, 0, 1, '1, 1, 64'hA5A5_A5A5_A5A5_A5A5);
    chk("R2 host all ones", s_rdata, BASE);
    chk("R2 guest pattern", vs_rdata, 64'hA5A5_A5A5_A5A5_A5A5 & BASE);

    phase = "R4";
    cyc(0, 0, 1, 1, 0, '0, 0, '0);
    chk("R4 henv blocked", henv_dte, 0);

    phase = "R3";
    cyc(1, 1, 0, 0, 0, '0, 0, '0);
    chk("R3 menv set", menv_dte, 1);
    cyc(0, 0, 1, 1, 0, '0, 0, '0);
    chk("R4 henv set", henv_dte, 1);

    phase = "R5";
    cyc(0, 0, 0, 0, 1, SDT_M, 0, '0);
    chk("R5 host flag written", s_sdt, 1);

    phase = "R7";
    cyc(0, 0, 0, 0, 1, SDT_M | SIE_M, 0, '0);
    chk("R7 both set sdt", s_sdt, 1);
    chk("R7 both set sie", s_sie, 0);
    cyc(0, 0, 0, 0, 1, SIE_M, 0, '0);
    chk("R7 sie after sdt clear", {s_sdt, s_sie}, 2'b01);

    phase = "R6";
    cyc(0, 0, 0, 0, 0, '0, 1, SDT_M | SIE_M);
    chk("R6 guest flag", {vs_sdt, vs_sie}, 2'b10);

    phase = "R8";
    cyc(0, 0, 0, 0, 1, SDT_M, 0, '0);
    cyc(1, 0, 0, 0, 0, '0, 0, '0);
    chk("R8 host flag hidden", s_sdt, 0);
    chk("R8 guest flag hidden", vs_sdt, 0);
    chk("R4 henv reads 0", henv_dte, 0);
    cyc(0, 0, 0, 0, 1, SIE_M, 0, '0);
    chk("R7 locked flag clears sie", s_sie, 0);
    cyc(1, 1, 0, 0, 0, '0, 0, '0);
    chk("R8 host flag returns", s_sdt, 1);
    chk("R4 henv returns", henv_dte, 1);
    chk("R8 guest flag returns", vs_sdt, 1);

    phase = "R9";
    cyc(1, 0, 0, 0, 1, SIE_M, 0, '0);
    chk("R9 menv now off", menv_dte, 0);
    chk("R9 sie written", s_sie, 1);
    cyc(1, 1, 0, 0, 0, '0, 0, '0);
    chk("R9 flag cleared by old enable", s_sdt, 0);
    cyc(1, 0, 0, 0, 0, '0, 0, '0);
    cyc(1, 1, 0, 0, 1, SDT_M, 0, '0);
    chk("R9 flag not set under old enable", s_sdt, 0);

    phase = "R2";
    for (int i = 0; i < 300; i++) begin
      cyc($urandom % 4 == 0, $urandom % 2, $urandom % 4 == 0, $urandom % 2,
          $urandom % 2, {$urandom, $urandom}, $urandom % 2, {$urandom, $urandom});
    end

    do_reset(1'b0);
    phase = "R10";
    cyc(1, 1, 1, 1, 1, SDT_M, 1, SDT_M);
    chk("R10 menv stays 0", menv_dte, 0);
    chk("R10 host flag", s_sdt, 0);
    chk("R10 guest flag", vs_sdt, 0);

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule